// File: doc/BRIEF.md
# Edge-Triggered Interrupt and Event Line Controller

This block watches a set of input lines and turns their transitions into interrupt requests and event pulses. Each line has its own edge detector. A line can be armed for rising transitions, falling transitions or both. The first part of the lines comes from general-purpose pins. For each of these lines, a small selector picks which pin port feeds it. The remaining lines are wired straight to internal peripheral event sources.

A detected edge sets a sticky pending bit. The pending bit stays set until software writes a one to it. The interrupt output of a line is its pending bit gated by that line's interrupt mask. Separately, an unmasked line emits a one-cycle event pulse that never passes through the pending register. Edge capture works without the bus clock. Each line drives per-edge toggle flops that are clocked by the line itself, and these toggles are then brought into the bus clock domain through two flops. As a result, a pulse narrower than one clock period is still seen. Software can also raise pending bits and events directly through a trigger register.

Configuration uses a plain register port with one write channel and a combinational read channel. There is no data stream and therefore no back-pressure: writes complete on the clock edge at which they are presented.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, and `irq_o` and `evt_o` are zero.
- R2: A line armed for rising edges (rising-enable register, address 0, bit = line) that sees a 0-to-1 transition has its pending bit (address 4) set no later than the third rising clock edge after the transition. It also fires one event pulse if its event mask bit is set.
- R3: A line armed only for falling edges (falling-enable register, address 1) reacts to a 1-to-0 transition and ignores 0-to-1 transitions.
- R4: A line with both enables set reacts to each transition separately, producing one event pulse per edge.
- R5: A transition on a line whose matching enable bit is clear sets no pending bit and produces no event.
- R6: A pulse that rises and falls again between two clock edges on a rising-armed line is still captured.
- R7: Writing address 4 clears exactly the pending bits written as one. Bits written as zero keep their value. If a new edge and a clear meet in the same cycle, the bit stays set.
- R8: `irq_o[i]` is high exactly when pending bit i and interrupt mask bit i (address 2) are both set. A clear mask bit does not stop the pending bit from being recorded.
- R9: `evt_o[i]` is a one-cycle pulse issued on a detection only when event mask bit i (address 3) is set. It is independent of the pending state.
- R10: Writing ones to address 5 sets those pending bits at the next clock edge and fires event pulses for the event-unmasked ones. Zero bits have no effect.
- R11: Line i below the pin-line count follows pin i of the port chosen by its 4-bit selector field. Lines 0–7 use address 6 and lines 8–15 use address 7, with field k at bits 4k+3..4k. Pins on other ports are ignored.
- R12: Lines from the pin-line count upward follow `periph_i` directly, with line 16+j taking `periph_i[j]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 4 | Read address |
| reg_rdata | output | 32 | Read data (combinational) |
| gpio_i | input | 80 | Pin inputs, port p pin n at bit 16p+n |
| periph_i | input | 12 | Internal peripheral event sources |
| irq_o | output | 28 | Per-line interrupt requests |
| evt_o | output | 28 | Per-line one-cycle event pulses |

## Verification
The hardest case to reach from the ports is a transition that starts and ends entirely between two clock edges. To create it, the stimulus raises and drops a pin within two nanoseconds of a falling clock edge, so no rising edge ever samples the high level. The run then checks that the pending bit is set and that exactly one event pulse is produced. The same scoreboard also catches any event that should not exist, such as one from an unarmed edge, a masked line or a pin on an unselected port.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int REG_AW = 4;
  localparam int REG_DW = 32;
  localparam int FIELD_W = 4;
  localparam int FIELDS_PER_WORD = REG_DW / FIELD_W;

  localparam logic [REG_AW-1:0] ADDR_RISE   = 4'd0;
  localparam logic [REG_AW-1:0] ADDR_FALL   = 4'd1;
  localparam logic [REG_AW-1:0] ADDR_IMASK  = 4'd2;
  localparam logic [REG_AW-1:0] ADDR_EMASK  = 4'd3;
  localparam logic [REG_AW-1:0] ADDR_PEND   = 4'd4;
  localparam logic [REG_AW-1:0] ADDR_SWTRIG = 4'd5;
  localparam logic [REG_AW-1:0] ADDR_PSEL0  = 4'd6;
endpackage

// File: rtl/eic_src_mux.sv
module eic_src_mux #(
  parameter int NL = 28,
  parameter int NG = 16,
  parameter int NP = 5,
  parameter int PSEL_W = 3
) (
  input  logic [NP*NG-1:0]     gpio_i,
  input  logic [NL-NG-1:0]     periph_i,
  input  logic [NG*PSEL_W-1:0] psel_i,
  output logic [NL-1:0]        line_o
);
  for (genvar l = 0; l < NL; l++) begin : g_line
    if (l < NG) begin : g_pin
      logic [PSEL_W-1:0] sel;
      assign sel = psel_i[l*PSEL_W +: PSEL_W];
      always_comb begin
        line_o[l] = 1'b0;
        for (int p = 0; p < NP; p++) begin
          if (sel == PSEL_W'(p)) line_o[l] = gpio_i[p*NG + l];
        end
      end
    end else begin : g_periph
      assign line_o[l] = periph_i[l-NG];
    end
  end
endmodule

// File: rtl/eic_edge_capture.sv
module eic_edge_capture #(
  parameter int NL = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] line_i,
  input  logic [NL-1:0] rise_en,
  input  logic [NL-1:0] fall_en,
  output logic [NL-1:0] hit_o
);
  localparam int SYNC_N = 3;

  for (genvar l = 0; l < NL; l++) begin : g_cap
    logic tog_r, tog_f;
    logic [SYNC_N-1:0] sr, sf;

    always_ff @(posedge line_i[l] or negedge rst_n) begin
      if (!rst_n) tog_r <= 1'b0;
      else        tog_r <= ~tog_r;
    end

    always_ff @(negedge line_i[l] or negedge rst_n) begin
      if (!rst_n) tog_f <= 1'b0;
      else        tog_f <= ~tog_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sr <= '0;
        sf <= '0;
      end else begin
        sr <= {sr[SYNC_N-2:0], tog_r};
        sf <= {sf[SYNC_N-2:0], tog_f};
      end
    end

    assign hit_o[l] = (rise_en[l] & (sr[SYNC_N-1] ^ sr[SYNC_N-2])) |
                      (fall_en[l] & (sf[SYNC_N-1] ^ sf[SYNC_N-2]));
  end
endmodule

// File: rtl/eic_regfile.sv
module eic_regfile
  import eic_pkg::*;
#(
  parameter int NL = 28,
  parameter int NG = 16,
  parameter int PSEL_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [REG_AW-1:0]    waddr,
  input  logic [REG_DW-1:0]    wdata,
  input  logic [REG_AW-1:0]    raddr,
  output logic [REG_DW-1:0]    rdata,
  input  logic [NL-1:0]        hit_i,
  output logic [NL-1:0]        rise_o,
  output logic [NL-1:0]        fall_o,
  output logic [NL-1:0]        pend_o,
  output logic [NL-1:0]        irq_o,
  output logic [NL-1:0]        evt_o,
  output logic [NG*PSEL_W-1:0] psel_o
);
  localparam int PSEL_WORDS = NG / FIELDS_PER_WORD;

  logic [NL-1:0] rise_q, fall_q, imask_q, emask_q, pend_q, evt_q;
  logic [NL-1:0] clr_v, sw_v, fire_v;
  logic [NG*PSEL_W-1:0] psel_q;
  logic unused_wdata;

  assign unused_wdata = ^wdata;
  assign clr_v  = (we && waddr == ADDR_PEND)   ? wdata[NL-1:0] : '0;
  assign sw_v   = (we && waddr == ADDR_SWTRIG) ? wdata[NL-1:0] : '0;
  assign fire_v = hit_i | sw_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q  <= '0;
      fall_q  <= '0;
      imask_q <= '0;
      emask_q <= '0;
    end else if (we) begin
      case (waddr)
        ADDR_RISE:  rise_q  <= wdata[NL-1:0];
        ADDR_FALL:  fall_q  <= wdata[NL-1:0];
        ADDR_IMASK: imask_q <= wdata[NL-1:0];
        ADDR_EMASK: emask_q <= wdata[NL-1:0];
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NG; g++) begin : g_psel
    localparam int WORD = g / FIELDS_PER_WORD;
    localparam int SLOT = g % FIELDS_PER_WORD;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) psel_q[g*PSEL_W +: PSEL_W] <= '0;
      else if (we && waddr == ADDR_PSEL0 + REG_AW'(WORD))
        psel_q[g*PSEL_W +: PSEL_W] <= wdata[SLOT*FIELD_W +: PSEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      evt_q  <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_v) | fire_v;
      evt_q  <= fire_v & emask_q;
    end
  end

  always_comb begin
    rdata = '0;
    case (raddr)
      ADDR_RISE:  rdata[NL-1:0] = rise_q;
      ADDR_FALL:  rdata[NL-1:0] = fall_q;
      ADDR_IMASK: rdata[NL-1:0] = imask_q;
      ADDR_EMASK: rdata[NL-1:0] = emask_q;
      ADDR_PEND:  rdata[NL-1:0] = pend_q;
      default: begin
        for (int w = 0; w < PSEL_WORDS; w++) begin
          if (raddr == ADDR_PSEL0 + REG_AW'(w)) begin
            for (int k = 0; k < FIELDS_PER_WORD; k++)
              rdata[k*FIELD_W +: PSEL_W] =
                psel_q[(w*FIELDS_PER_WORD + k)*PSEL_W +: PSEL_W];
          end
        end
      end
    endcase
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign pend_o = pend_q;
  assign irq_o  = pend_q & imask_q;
  assign evt_o  = evt_q;
  assign psel_o = psel_q;
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_LINES      = 28,
  parameter int NUM_GPIO_LINES = 16,
  parameter int NUM_PORTS      = 5
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               reg_we,
  input  logic [3:0]                         reg_addr,
  input  logic [31:0]                        reg_wdata,
  input  logic [3:0]                         reg_raddr,
  output logic [31:0]                        reg_rdata,
  input  logic [NUM_PORTS*NUM_GPIO_LINES-1:0] gpio_i,
  input  logic [NUM_LINES-NUM_GPIO_LINES-1:0] periph_i,
  output logic [NUM_LINES-1:0]               irq_o,
  output logic [NUM_LINES-1:0]               evt_o
);
  localparam int PSEL_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  logic [NUM_LINES-1:0] line, hit, rise_en, fall_en, pend;
  logic [NUM_GPIO_LINES*PSEL_W-1:0] psel;

  eic_src_mux #(
    .NL(NUM_LINES), .NG(NUM_GPIO_LINES), .NP(NUM_PORTS), .PSEL_W(PSEL_W)
  ) u_mux (
    .gpio_i(gpio_i), .periph_i(periph_i), .psel_i(psel), .line_o(line)
  );

  eic_edge_capture #(.NL(NUM_LINES)) u_cap (
    .clk(clk), .rst_n(rst_n), .line_i(line),
    .rise_en(rise_en), .fall_en(fall_en), .hit_o(hit)
  );

  eic_regfile #(
    .NL(NUM_LINES), .NG(NUM_GPIO_LINES), .PSEL_W(PSEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .waddr(reg_addr),
    .wdata(reg_wdata), .raddr(reg_raddr), .rdata(reg_rdata),
    .hit_i(hit), .rise_o(rise_en), .fall_o(fall_en), .pend_o(pend),
    .irq_o(irq_o), .evt_o(evt_o), .psel_o(psel)
  );
endmodule

// File: rtl/eic_checker.sv
module eic_checker
  import eic_pkg::*;
#(
  parameter int NL = 28
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [3:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic [NL-1:0] irq_o,
  input logic [NL-1:0] evt_o,
  input logic [NL-1:0] pend
);
  logic [NL-1:0] sh_rise, sh_fall, sh_imask, sh_emask, clr_vec, sw_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_rise <= '0; sh_fall <= '0; sh_imask <= '0; sh_emask <= '0;
    end else if (reg_we) begin
      if (reg_addr == ADDR_RISE)  sh_rise  <= reg_wdata[NL-1:0];
      if (reg_addr == ADDR_FALL)  sh_fall  <= reg_wdata[NL-1:0];
      if (reg_addr == ADDR_IMASK) sh_imask <= reg_wdata[NL-1:0];
      if (reg_addr == ADDR_EMASK) sh_emask <= reg_wdata[NL-1:0];
    end
  end

  assign clr_vec = (reg_we && reg_addr == ADDR_PEND)   ? reg_wdata[NL-1:0] : '0;
  assign sw_vec  = (reg_we && reg_addr == ADDR_SWTRIG) ? reg_wdata[NL-1:0] : '0;

  assert_pend_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pend) & ~pend & ~$past(clr_vec)) == '0));

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq_o & ~sh_imask) == '0));

  assert_evt_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_o & ~sh_emask) == '0));

  assert_evt_has_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_o & ~pend) == '0));

  assert_swtrig_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_vec != '0) |=> ((pend & $past(sw_vec)) == $past(sw_vec)));

  assert_no_unarmed_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~($past(sh_rise | sh_fall) | $past(sw_vec))) == '0));
endmodule

bind edge_irq_ctrl eic_checker #(.NL(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq_o(irq_o), .evt_o(evt_o), .pend(pend)
);

// File: tb/test_edge_irq_ctrl.sv
`timescale 1ns/1ps
module test_edge_irq_ctrl;
  localparam int NL = 28;
  localparam int NG = 16;
  localparam int NP = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [3:0] reg_addr = '0, reg_raddr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [NP*NG-1:0] gpio = '0;
  logic [NL-NG-1:0] periph = '0;
  logic [NL-1:0] irq_o, evt_o;

  int checks = 0, failures = 0;
  logic [NL-1:0] exp_q[$];
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  edge_irq_ctrl i_edge_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .gpio_i(gpio), .periph_i(periph), .irq_o(irq_o), .evt_o(evt_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_raddr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic expect_evt(input int line);
    exp_q.push_back(NL'(1) << line);
  endtask

  // Monitor: every event pulse is popped and compared against the queue.
  always @(negedge clk) begin
    if (rst_n && evt_o != '0) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R9 unexpected event actual=%h expected=0", evt_o);
      end else begin
        logic [NL-1:0] e;
        e = exp_q.pop_front();
        if (evt_o !== e) begin
          failures++;
          $display("FAIL R2 event actual=%h expected=%h", evt_o, e);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(4'(a), d);
      check("R1 reg", d, 32'h0);
    end
    check("R1 irq", 32'(irq_o), 32'h0);
    check("R1 evt", 32'(evt_o), 32'h0);

    wr(4'd0, 32'h0008_0175);           // rising: 0,2,4,5,6,8,19
    wr(4'd1, 32'h0000_0006);           // falling: 1,2
    wr(4'd2, 32'h0000_0001);           // irq mask: line 0
    wr(4'd3, 32'h0FFF_FFBF);           // events all but line 6

    // R2 rising edge, R8 irq follows pending & mask
    expect_evt(0);
    gpio[0] = 1'b1;
    idle(5);
    rd(4'd4, d); check("R2 pend", d, 32'h1);
    check("R8 irq on", 32'(irq_o), 32'h1);
    // R7 write zero has no effect, then write one clears
    wr(4'd4, 32'h0);
    rd(4'd4, d); check("R7 zero write", d, 32'h1);
    wr(4'd4, 32'h1);
    idle(1);
    rd(4'd4, d); check("R7 clear", d, 32'h0);
    check("R8 irq off", 32'(irq_o), 32'h0);

    // R3 falling only: rising ignored
    gpio[1] = 1'b1;
    idle(5);
    rd(4'd4, d); check("R3 rise ignored", d, 32'h0);
    expect_evt(1);
    gpio[1] = 1'b0;
    idle(5);
    rd(4'd4, d); check("R3 fall", d, 32'h2);
    wr(4'd4, 32'hFFFF_FFFF);

    // R4 both edges, each separately
    expect_evt(2);
    gpio[2] = 1'b1;
    idle(5);
    rd(4'd4, d); check("R4 rise", d, 32'h4);
    wr(4'd4, 32'h4);
    expect_evt(2);
    gpio[2] = 1'b0;
    idle(5);
    rd(4'd4, d); check("R4 fall", d, 32'h4);
    wr(4'd4, 32'h4);

    // R5 line 3 not armed
    gpio[3] = 1'b1; idle(4); gpio[3] = 1'b0; idle(5);
    rd(4'd4, d); check("R5 unarmed", d, 32'h0);

    // R6 narrow pulse between clock edges
    expect_evt(4);
    @(negedge clk);
    #0.5 gpio[4] = 1'b1;
    #1.0 gpio[4] = 1'b0;
    idle(5);
    rd(4'd4, d); check("R6 narrow", d, 32'h10);
    wr(4'd4, 32'h10);

    // R8 interrupt mask clear still records pending
    expect_evt(5);
    gpio[5] = 1'b1;
    idle(5);
    rd(4'd4, d); check("R8 masked pend", d, 32'h20);
    check("R8 masked irq", 32'(irq_o), 32'h0);
    wr(4'd4, 32'h20);

    // R9 event mask clear: pending only, no pulse
    gpio[6] = 1'b1;
    idle(5);
    rd(4'd4, d); check("R9 no evt pend", d, 32'h40);
    wr(4'd4, 32'h40);

    // R10 software trigger
    exp_q.push_back(NL'(32'h0010_0080));
    wr(4'd5, 32'h0010_0080);
    rd(4'd4, d); check("R10 swtrig", d, 32'h0010_0080);
    idle(2);
    wr(4'd4, 32'h0010_0080);

    // R11 line 8 moved to port 2
    wr(4'd7, 32'h0000_0002);
    rd(4'd7, d); check("R11 psel read", d, 32'h2);
    gpio[8] = 1'b1; idle(5);
    rd(4'd4, d); check("R11 other port", d, 32'h0);
    expect_evt(8);
    gpio[2*NG + 8] = 1'b1; idle(5);
    rd(4'd4, d); check("R11 chosen port", d, 32'h100);
    wr(4'd4, 32'h100);

    // R12 peripheral line 19 from periph[3]
    expect_evt(19);
    periph[3] = 1'b1; idle(5);
    rd(4'd4, d); check("R12 periph", d, 32'h0008_0000);

    idle(4);
    check("R9 queue drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule